// File: doc/BRIEF.md
# Dual-Source Reset Pulse Generator

This block makes one active-low reset pulse for a processor from two kinds of request. The first is an instant trigger: an active-high input whose rising edge starts a pulse at once. Its falling edge then opens a long lockout window, so contact bounce on release cannot start a second pulse. The second is a delayed button: an active-low push-button that must stay pressed for a selectable setup time before it counts. A short press gets no response, so the same button can also serve as an interrupt source.

Both sources feed one timeout counter. Any accepted request loads the full timeout, and the output stays low until that count runs out. Overlapping requests therefore stretch a single pulse and do not split it into two. All windows are counted in prescaled ticks of `TICK_DIV` clock cycles, so millisecond and second windows use narrow counters. Both inputs pass through `SYNC_STAGES` flip-flops before any decision is made.

Top module: `dual_src_reset`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first accepted request, `rst_n_o` is high.
- R2: A rising edge of `trig_i` outside the lockout window is accepted. `rst_n_o` goes low on the third clock edge after `trig_i` rises: two synchronizer stages, then the pulse counter.
- R3: Once a request has been accepted and no further request arrives, `rst_n_o` stays low for exactly `PULSE_TICKS` ticks and then returns high.
- R4: A falling edge of `trig_i` that ends an accepted press starts a lockout of `LOCK_TICKS` ticks. With one tick per cycle, a rise driven m cycles after the fall is ignored for m up to `LOCK_TICKS` and accepted for m = `LOCK_TICKS`+1. The falling edge itself never starts a pulse.
- R5: The falling edge of a press that was ignored starts no new lockout window.
- R6: `btn_n_i` held low for the selected hold time starts a pulse. The hold time is `HOLD_T0` ticks for `sel_i`=2'b00, `HOLD_T1` for 2'b01, and `HOLD_T2` for 2'b10 and for 2'b11. With one tick per cycle, the output goes low on clock edge hold+2 after the press is driven.
- R7: A press shorter than the selected hold time produces no output response.
- R8: A press gives at most one pulse. Holding the button after it has fired gives nothing more until it is released.
- R9: A request accepted while a pulse is running restarts the timeout, so the output stays low for a full `PULSE_TICKS` from that request, whichever source made it.
- R10: The two sources are independent. A held button does not block the trigger, and a trigger held high does not block the button.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| trig_i | input | 1 | Instant trigger, active high, edge-sensitive |
| btn_n_i | input | 1 | Push-button, active low, level-sensitive with hold time |
| sel_i | input | 2 | Hold-time select (00 short, 01 middle, 10/11 long); held static |
| rst_n_o | output | 1 | Reset pulse output, active low |

## Verification
The assertions check every cycle that an accepted trigger pulls the output low on the next edge, and that a rise inside the lockout cannot start a pulse. They also check that a low output never outlives the timeout since the latest request and never ends before it, that a button request only follows a low run long enough for the selected hold, and that a held button fires once. Only the bench's scenarios show the exact edge on which a pulse begins after either source, the precise end of the lockout window, the effect of falls that end ignored presses, and the reset state. The bench sweeps the release-to-repress gap across the whole lockout, every select code, every too-short hold length, and overlaps from both sources.

// File: rtl/rstc_pkg.sv
// Shared definitions for the dual-source reset generator.
// Assumes hold-time selection is a static 2-bit code.
package rstc_pkg;

    typedef enum logic [1:0] {
        HOLD_SHORT    = 2'b00,
        HOLD_MID      = 2'b01,
        HOLD_LONG     = 2'b10,
        HOLD_LONG_ALT = 2'b11
    } hold_sel_e;

    // Map a select code to its hold length in ticks.
    function automatic int hold_limit(input logic [1:0] sel, input int t0, input int t1, input int t2);
        case (hold_sel_e'(sel))
            HOLD_SHORT: return t0;
            HOLD_MID:   return t1;
            default:    return t2;
        endcase
    endfunction

    // Largest of three values, used to size counters.
    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/rstc_tick_gen.sv
// Tick prescaler: produces a one-cycle strobe every TICK_DIV clocks.
// Assumes TICK_DIV >= 1; with TICK_DIV == 1 the strobe is constant high.
module rstc_tick_gen #(
    parameter int TICK_DIV = 1000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);

    generate
        if (TICK_DIV <= 1) begin : g_every
            logic unused_ok;
            assign unused_ok = clk & rst_n;
            assign tick_o    = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(TICK_DIV);
            logic [CW-1:0] div_q;

            // Free-running divider that wraps at TICK_DIV-1.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    div_q <= '0;
                else if (div_q == CW'(TICK_DIV - 1))
                    div_q <= '0;
                else
                    div_q <= div_q + 1'b1;
            end

            assign tick_o = (div_q == CW'(TICK_DIV - 1));
        end
    endgenerate

endmodule

// File: rtl/rstc_sync.sv
// Level synchronizer for an asynchronous input.
// Assumes STAGES >= 2; RST_VAL is the inactive level of the input.
module rstc_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] pipe_q;

    // Shift the input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pipe_q <= {STAGES{RST_VAL}};
        else
            pipe_q <= {pipe_q[STAGES-2:0], d_i};
    end

    assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/rstc_edge_gate.sv
// Edge detector with release lockout for the instant trigger (R2, R4, R5).
// A rise is accepted only when no lockout is running. The fall that ends an
// accepted press loads a LOCK_TICKS window. Falls of ignored presses are
// not armed and start nothing.
// Assumes lvl_i is already synchronized and LOCK_TICKS >= 1.
module rstc_edge_gate #(
    parameter int LOCK_TICKS = 360
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic lvl_i,
    output logic rise_o,
    output logic fire_o,
    output logic lock_o
);

    localparam int LW = $clog2(LOCK_TICKS + 1);

    logic          prev_q;
    logic          armed_q;
    logic [LW-1:0] lock_q;
    logic          fall;

    assign rise_o = lvl_i & ~prev_q;
    assign fall   = ~lvl_i & prev_q;
    assign lock_o = (lock_q != '0);
    assign fire_o = rise_o & ~lock_o;

    // Remember the previous level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl_i;
    end

    // Track whether the current press was accepted (R5).
    always_ff @(posedge clk) begin
        if (!rst_n)      armed_q <= 1'b0;
        else if (fire_o) armed_q <= 1'b1;
        else if (fall)   armed_q <= 1'b0;
    end

    // Lockout window: load on an armed fall, count down on ticks (R4).
    always_ff @(posedge clk) begin
        if (!rst_n)
            lock_q <= '0;
        else if (fall && armed_q)
            lock_q <= LW'(LOCK_TICKS);
        else if (lock_o && tick_i)
            lock_q <= lock_q - 1'b1;
    end

endmodule

// File: rtl/rstc_hold_timer.sv
// Hold-time qualifier for the active-low button (R6, R7, R8).
// Counts ticks while the button is pressed and fires once when the
// selected hold is reached; release clears the counter and re-arms.
// Assumes btn_low_i is synchronized, sel_i is static, hold values >= 1.
module rstc_hold_timer #(
    parameter int HOLD_T0 = 2000,
    parameter int HOLD_T1 = 6000,
    parameter int HOLD_T2 = 10000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       btn_low_i,
    input  logic [1:0] sel_i,
    output logic       fire_o
);

    localparam int MAXD = rstc_pkg::max3(HOLD_T0, HOLD_T1, HOLD_T2);
    localparam int HW   = $clog2(MAXD + 1);

    logic [HW-1:0] cnt_q;
    logic [HW-1:0] lim_m1;
    logic          done_q;

    // Last count value before the selected hold is complete.
    always_comb lim_m1 = HW'(rstc_pkg::hold_limit(sel_i, HOLD_T0, HOLD_T1, HOLD_T2) - 1);

    assign fire_o = btn_low_i & ~done_q & tick_i & (cnt_q >= lim_m1);

    // Count held ticks; one shot per press (R8).
    always_ff @(posedge clk) begin
        if (!rst_n || !btn_low_i) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (fire_o) begin
            done_q <= 1'b1;
        end else if (tick_i && !done_q && cnt_q < HW'(MAXD)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/dual_src_reset.sv
// Dual-source reset pulse generator (top).
// An instant edge-triggered request and a hold-qualified button request
// share one timeout counter. Any accepted request reloads the full
// timeout (R9). The output is low while the counter is non-zero.
// Assumes all window parameters are >= 1 and SYNC_STAGES >= 2.
module dual_src_reset #(
    parameter int TICK_DIV    = 1000,
    parameter int SYNC_STAGES = 2,
    parameter int PULSE_TICKS = 240,
    parameter int LOCK_TICKS  = 360,
    parameter int HOLD_T0     = 2000,
    parameter int HOLD_T1     = 6000,
    parameter int HOLD_T2     = 10000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trig_i,
    input  logic       btn_n_i,
    input  logic [1:0] sel_i,
    output logic       rst_n_o
);

    localparam int PW = $clog2(PULSE_TICKS + 1);

    logic          tick;
    logic          trig_lvl;
    logic          btn_lvl;
    logic          btn_low;
    logic          trig_rise;
    logic          trig_fire;
    logic          lock_on;
    logic          btn_fire;
    logic          req_any;
    logic [PW-1:0] pulse_q;

    rstc_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick_o(tick)
    );

    rstc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_trig (
        .clk(clk), .rst_n(rst_n), .d_i(trig_i), .q_o(trig_lvl)
    );

    rstc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_btn (
        .clk(clk), .rst_n(rst_n), .d_i(btn_n_i), .q_o(btn_lvl)
    );

    assign btn_low = ~btn_lvl;

    rstc_edge_gate #(.LOCK_TICKS(LOCK_TICKS)) u_edge (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .lvl_i(trig_lvl),
        .rise_o(trig_rise), .fire_o(trig_fire), .lock_o(lock_on)
    );

    rstc_hold_timer #(.HOLD_T0(HOLD_T0), .HOLD_T1(HOLD_T1), .HOLD_T2(HOLD_T2)) u_hold (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .btn_low_i(btn_low),
        .sel_i(sel_i), .fire_o(btn_fire)
    );

    assign req_any = trig_fire | btn_fire;

    // Shared timeout: reload on any request, count down on ticks (R3, R9).
    always_ff @(posedge clk) begin
        if (!rst_n)
            pulse_q <= '0;
        else if (req_any)
            pulse_q <= PW'(PULSE_TICKS);
        else if (pulse_q != '0 && tick)
            pulse_q <= pulse_q - 1'b1;
    end

    // Active-low output while the timeout runs (R1).
    assign rst_n_o = (pulse_q == '0);

endmodule

// File: rtl/dual_src_reset_chk.sv
// Property checker for dual_src_reset, attached by bind.
// Keeps its own counters of cycles since the last request and of the
// button's low run, so that the long windows need no deep $past.
module dual_src_reset_chk #(
    parameter int TICK_DIV    = 1000,
    parameter int PULSE_TICKS = 240,
    parameter int HOLD_T0     = 2000,
    parameter int HOLD_T1     = 6000,
    parameter int HOLD_T2     = 10000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       rst_n_o,
    input logic       trig_rise,
    input logic       trig_fire,
    input logic       lock_on,
    input logic       btn_fire,
    input logic       btn_low,
    input logic [1:0] sel,
    input logic       req_any
);

    localparam int SPAN    = PULSE_TICKS * TICK_DIV;
    localparam int SW      = $clog2(SPAN + 1) + 1;
    localparam int MIN_LOW = (PULSE_TICKS - 1) * TICK_DIV + 1;
    localparam int RUN_MAX = rstc_pkg::max3(HOLD_T0, HOLD_T1, HOLD_T2) * TICK_DIV;
    localparam int RW      = $clog2(RUN_MAX + 1) + 1;

    logic [SW-1:0] since_req;
    logic [RW-1:0] btn_run;
    logic [RW-1:0] need_run;

    // Cycles since the latest request, saturating at SPAN.
    always_ff @(posedge clk) begin
        if (!rst_n)              since_req <= SW'(SPAN);
        else if (req_any)        since_req <= '0;
        else if (since_req < SW'(SPAN)) since_req <= since_req + 1'b1;
    end

    // Consecutive cycles with the synchronized button low, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || !btn_low)  btn_run <= '0;
        else if (btn_run < RW'(RUN_MAX)) btn_run <= btn_run + 1'b1;
    end

    // Shortest prior low run allowed before a button request.
    always_comb need_run = RW'((rstc_pkg::hold_limit(sel, HOLD_T0, HOLD_T1, HOLD_T2) - 1) * TICK_DIV);

    AST_TRIG_STARTS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        trig_fire |=> !rst_n_o); // R2

    AST_LOCK_IGNORES_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_rise && lock_on && !btn_fire && rst_n_o) |=> rst_n_o); // R4

    AST_LOW_NOT_TOO_LONG: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_n_o |-> (since_req < SW'(SPAN))); // R3

    AST_LOW_NOT_TOO_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n_o |-> (since_req >= SW'(MIN_LOW))); // R9

    AST_BTN_HOLD_MET: assert property (@(posedge clk) disable iff (!rst_n)
        btn_fire |-> (btn_run >= need_run)); // R7

    AST_BTN_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        btn_fire |=> !btn_fire); // R8

endmodule

bind dual_src_reset dual_src_reset_chk #(
    .TICK_DIV(TICK_DIV), .PULSE_TICKS(PULSE_TICKS),
    .HOLD_T0(HOLD_T0), .HOLD_T1(HOLD_T1), .HOLD_T2(HOLD_T2)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rst_n_o(rst_n_o), .trig_rise(trig_rise),
    .trig_fire(trig_fire), .lock_on(lock_on), .btn_fire(btn_fire),
    .btn_low(btn_low), .sel(sel_i), .req_any(req_any)
);

// File: tb/dual_src_reset_tb.sv
// Self-checking bench: sweeps lockout gaps, select codes, hold lengths
// and overlaps on a small configuration with one tick per clock.
module dual_src_reset_tb;

    localparam int CLK_PERIOD = 10;
    localparam int P   = 6;
    localparam int DEB = 5;
    localparam int D0  = 3;
    localparam int D1  = 5;
    localparam int D2  = 8;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       trig;
    logic       btn_n;
    logic [1:0] sel;
    logic       rst_n_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    dual_src_reset #(
        .TICK_DIV(1), .SYNC_STAGES(2), .PULSE_TICKS(P), .LOCK_TICKS(DEB),
        .HOLD_T0(D0), .HOLD_T1(D1), .HOLD_T2(D2)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .trig_i(trig), .btn_n_i(btn_n),
        .sel_i(sel), .rst_n_o(rst_n_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int lim_of(input int s);
        case (s)
            0: return D0;
            1: return D1;
            default: return D2;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Negedges until the output is seen low (-1 if never within maxn).
    task automatic wait_low(input int maxn, output int t);
        t = -1;
        for (int i = 1; i <= maxn; i++) begin
            @(negedge clk);
            if (!rst_n_o) begin
                t = i;
                break;
            end
        end
    endtask

    // Length of the current low run, returning at the first high negedge.
    task automatic count_low(output int len);
        len = 1;
        forever begin
            @(negedge clk);
            if (rst_n_o || len > 1000) break;
            len++;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog all-requirements actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int t;
        int len;
        int L;
        rst_n = 1'b0; trig = 1'b0; btn_n = 1'b1; sel = 2'b00;
        idle(3);
        check(rst_n_o == 1'b1, "R1 high in reset", rst_n_o, 1);
        trig = 1'b1;
        idle(4);
        check(rst_n_o == 1'b1, "R1 trigger ignored in reset", rst_n_o, 1);
        trig = 1'b0;
        idle(4);
        rst_n = 1'b1;
        idle(4);
        check(rst_n_o == 1'b1, "R1 high after reset", rst_n_o, 1);

        // R2 / R3: repeated trigger pulses, each after the lockout has ended
        for (int k = 0; k < 3; k++) begin
            trig = 1'b1;
            wait_low(8, t);
            check(t == 3, "R2 trigger latency", t, 3);
            count_low(len);
            check(len == P, "R3 pulse length", len, P);
            trig = 1'b0;
            idle(DEB + 4);
            check(rst_n_o == 1'b1, "R4 fall gives no pulse", rst_n_o, 1);
        end

        // R4: sweep the release-to-repress gap across the lockout
        for (int m = 1; m <= DEB + 2; m++) begin
            trig = 1'b1;
            wait_low(8, t);
            count_low(len);
            trig = 1'b0;
            idle(m);
            trig = 1'b1;
            wait_low(8, t);
            if (m > DEB) check(t == 3, "R4 rise after lockout accepted", t, 3);
            else         check(t == -1, "R4 rise in lockout ignored", t, -1);
            trig = 1'b0;
            idle(DEB + P + 4);
        end

        // R5: a bounce inside the lockout does not extend the window
        trig = 1'b1;
        wait_low(8, t);
        count_low(len);
        trig = 1'b0;
        idle(2);
        trig = 1'b1;
        idle(2);
        trig = 1'b0;
        idle(DEB + 1 - 4);
        trig = 1'b1;
        wait_low(8, t);
        check(t == 3, "R5 ignored press fall opens no window", t, 3);
        if (t != -1) count_low(len);
        trig = 1'b0;
        idle(DEB + P + 4);

        // R6 / R8: every select code, exact hold, then keep holding
        for (int s = 0; s < 4; s++) begin
            sel = 2'(s);
            L = lim_of(s);
            btn_n = 1'b0;
            wait_low(L + 6, t);
            check(t == L + 2, "R6 hold latency", t, L + 2);
            count_low(len);
            check(len == P, "R6 button pulse length", len, P);
            wait_low(2 * L + 4, t);
            check(t == -1, "R8 single pulse per press", t, -1);
            btn_n = 1'b1;
            idle(4);
        end

        // R7: every too-short hold for every select code
        for (int s = 0; s < 4; s++) begin
            sel = 2'(s);
            L = lim_of(s);
            for (int n = 1; n < L; n++) begin
                btn_n = 1'b0;
                idle(n);
                btn_n = 1'b1;
                wait_low(L + 6, t);
                check(t == -1, "R7 short hold ignored", t, -1);
            end
        end

        // R9: button request during a trigger pulse restarts the timeout
        sel = 2'b00;
        trig = 1'b1;
        idle(1);
        btn_n = 1'b0;
        wait_low(8, t);
        check(t == 2, "R9 trigger start", t, 2);
        count_low(len);
        check(len == P + 3, "R9 button restarts timeout", len, P + 3);
        btn_n = 1'b1;
        trig = 1'b0;
        idle(DEB + P + 4);

        // R9: trigger request during a button pulse restarts the timeout
        btn_n = 1'b0;
        idle(4);
        trig = 1'b1;
        wait_low(8, t);
        check(t == 1, "R9 button start", t, 1);
        count_low(len);
        check(len == P + 2, "R9 trigger restarts timeout", len, P + 2);
        btn_n = 1'b1;
        trig = 1'b0;
        idle(DEB + P + 4);

        // R10: each source works while the other is held active
        sel = 2'b10;
        L = D2;
        btn_n = 1'b0;
        wait_low(L + 6, t);
        count_low(len);
        trig = 1'b1;
        wait_low(8, t);
        check(t == 3, "R10 trigger with button held", t, 3);
        count_low(len);
        check(len == P, "R10 trigger pulse length", len, P);
        btn_n = 1'b1;
        idle(3);
        btn_n = 1'b0;
        wait_low(L + 6, t);
        check(t == L + 2, "R10 button with trigger held", t, L + 2);
        count_low(len);
        btn_n = 1'b1;
        trig = 1'b0;
        idle(DEB + P + 4);
        check(rst_n_o == 1'b1, "R3 idle at end", rst_n_o, 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule